// File: doc/BRIEF.md
# Pipelined Unified CORDIC Engine

This block is a fully pipelined shift-and-add engine for signed fixed-point vectors. Each operand carries a two-dimensional vector (x, y), an angle or auxiliary value z, an operation select (rotate or vector) and a coordinate-system select (circular, linear or hyperbolic). The operand first passes a pre-rotation register, which extends the circular range to the whole plane. It then passes one register per micro-rotation. A new operand may enter on every clock. The x and y results carry the uncompensated gain of the coordinate system that was chosen. Any gain correction is left to the consumer.

The block's uses follow from the select pair:

- Circular rotation gives sine and cosine, or rotates a vector.
- Circular vectoring gives magnitude and phase.
- Linear rotation gives a multiply-accumulate.
- Linear vectoring gives a divide-accumulate.
- The hyperbolic pair gives cosh/sinh and atanh/root-of-difference-of-squares.

Each stage selects its direction from the sign of z (rotate) or from the sign of y (vector). Each stage uses only hardwired shifts.

Top module: `cordic_pipe`

## Requirements
- R1: Circular rotate (in_mode=0, in_coord=0): out_x ≈ K·(x·cos z − y·sin z) and out_y ≈ K·(y·cos z + x·sin z), with K ≈ 1.6467605. z is signed with ZW−3 fraction bits, which is 15 for the default ZW=18 (radians × 32768). The result is within 24 LSB on x/y.
- R2: Circular vector (in_mode=1, in_coord=0): out_x ≈ K·√(x²+y²), out_y ≈ 0 and out_z ≈ z + atan2(y, x), for vectors in any quadrant. This includes x < 0. z is within 0.002.
- R3: In circular rotate, angles up to ±π (beyond ±π/2) are first turned by ±90° and still satisfy R1.
- R4: Linear rotate (in_coord=1): out_x equals in_x exactly, and out_y ≈ y + x·z.
- R5: Linear vector: out_z ≈ z + y/x, for |y/x| < 2 and x > 0.
- R6: Hyperbolic rotate (in_coord=2): out_x ≈ Kh·(x·cosh z + y·sinh z) and out_y ≈ Kh·(y·cosh z + x·sinh z), with Kh ≈ 0.82816, for |z| ≤ 1.1.
- R7: Hyperbolic vector: out_x ≈ Kh·√(x²−y²) and out_z ≈ z + atanh(y/x), for |y/x| ≤ 0.8.
- R8: The latency is N + R + 1 clocks. N is the number of micro-rotation stages (default 14). R counts the hyperbolic repeats of shifts 4 and 13 that fall within N (2 by default, so 17 clocks). One operand is accepted every clock. out_valid, out_mode and out_coord emerge with the matching result.
- R9: While rst_n is low, and on the first clock after it, out_valid is 0 whatever in_valid is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_mode | input | 1 | 0 rotate (steer on z), 1 vector (steer on y) |
| in_coord | input | 2 | 0 circular, 1 linear, 2 hyperbolic |
| in_x | input | DW | Signed x operand |
| in_y | input | DW | Signed y operand |
| in_z | input | ZW | Signed z operand, ZW−3 fraction bits |
| out_valid | output | 1 | Result present this cycle |
| out_mode | output | 1 | Mode that travelled with the result |
| out_coord | output | 2 | Coordinate select that travelled with the result |
| out_x | output | DW+2 | Signed x result, gain included |
| out_y | output | DW+2 | Signed y result, gain included |
| out_z | output | ZW | Signed z result |

## Verification
Every result is due exactly 17 rising edges after the edge that captures the operand: one pre-rotation register plus sixteen stage registers. No result is due earlier or later. Each directed task applies its operand on a falling edge and drops in_valid on the next falling edge. It then waits the remaining 16 rising edges and samples on the following falling edge. The latency scenario also samples one cycle before and one cycle after the due cycle. The back-to-back scenario reads three results on three consecutive falling edges, starting 17 edges after the first operand.

// File: rtl/cordic_pkg.sv
// Shared types and elaboration helpers for the CORDIC pipeline.
// Assumes the hyperbolic sequence starts at shift 1 and repeats shifts 4 and 13.
package cordic_pkg;

    typedef enum logic {
        MD_ROTATE = 1'b0,
        MD_VECTOR = 1'b1
    } cmode_e;

    typedef enum logic [1:0] {
        CS_CIRC = 2'd0,
        CS_LIN  = 2'd1,
        CS_HYP  = 2'd2
    } csys_e;

    // Shift index used by hyperbolic stage s (1,2,3,4,4,5,...,13,13,14,...).
    function automatic int hyp_shift(input int s);
        int k;
        bit done_rep;
        k = 1;
        done_rep = 1'b0;
        for (int j = 0; j < s; j++) begin
            if ((k == 4 || k == 13) && !done_rep) begin
                done_rep = 1'b1;
            end else begin
                k++;
                done_rep = 1'b0;
            end
        end
        return k;
    endfunction

    // Number of repeated hyperbolic shifts that fall inside n base stages.
    function automatic int hyp_repeats(input int n);
        return (n >= 13) ? 2 : ((n >= 4) ? 1 : 0);
    endfunction

endpackage

// File: rtl/cordic_prerot.sv
// Entry register of the pipeline. Sign-extends x/y by the guard bits and,
// for circular operands only, turns the vector by +/-90 degrees so that
// the micro-rotations only ever see a right-half-plane problem.
// Assumes z is radians with FZ fraction bits and |z| <= pi in rotate mode.
module cordic_prerot
    import cordic_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = 18,
    parameter int ZW = 18,
    parameter int FZ = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  cmode_e               mode_i,
    input  csys_e                coord_i,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] y_i,
    input  logic signed [ZW-1:0] z_i,
    output logic                 vld_o,
    output cmode_e               mode_o,
    output csys_e                coord_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);
    localparam real SC = 2.0 ** FZ;
    localparam logic signed [ZW-1:0] HALF_PI = ZW'($rtoi(1.5707963267948966 * SC + 0.5));
    localparam logic signed [ZW-1:0] FULL_PI = ZW'($rtoi(3.141592653589793 * SC + 0.5));

    logic signed [IW-1:0] xe, ye, xn, yn;
    logic signed [ZW-1:0] zn;

    assign xe = IW'(x_i);
    assign ye = IW'(y_i);

    // Select the quarter-turn needed for this operand.
    always_comb begin
        xn = xe;
        yn = ye;
        zn = z_i;
        if (coord_i == CS_CIRC) begin
            if (mode_i == MD_ROTATE) begin
                if (z_i > HALF_PI) begin
                    xn = -ye;
                    yn = xe;
                    zn = z_i - HALF_PI;
                end else if (z_i < -HALF_PI) begin
                    xn = ye;
                    yn = -xe;
                    zn = z_i + HALF_PI;
                end
            end else if (xe < 0) begin
                if (ye >= 0) begin
                    xn = ye;
                    yn = -xe;
                    zn = z_i + HALF_PI;
                end else begin
                    xn = -ye;
                    yn = xe;
                    zn = z_i - HALF_PI;
                end
            end
        end
    end

    // Valid bit is reset; payload registers just follow.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
        mode_o  <= mode_i;
        coord_o <= coord_i;
        x_o     <= xn;
        y_o     <= yn;
        z_o     <= zn;
    end

    AST_PREROT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && coord_i == CS_CIRC && mode_i == MD_ROTATE && z_i <= FULL_PI && z_i >= -FULL_PI)
        |=> (z_o <= HALF_PI && z_o >= -HALF_PI)); // R3

    AST_PREROT_XPOS: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && coord_i == CS_CIRC && mode_i == MD_VECTOR) |=> (x_o >= 0)); // R2

endmodule

// File: rtl/cordic_stage.sv
// One registered micro-rotation. Shift amounts are fixed by STAGE (plain
// wiring). Circular and linear stages shift by STAGE, hyperbolic stages by
// the repeated sequence. Angle constants are rounded to the z format.
// Assumes guard bits in IW absorb the gain growth.
module cordic_stage
    import cordic_pkg::*;
#(
    parameter int IW    = 18,
    parameter int ZW    = 18,
    parameter int FZ    = 15,
    parameter int STAGE = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  cmode_e               mode_i,
    input  csys_e                coord_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic signed [ZW-1:0] z_i,
    output logic                 vld_o,
    output cmode_e               mode_o,
    output csys_e                coord_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);
    localparam int  CSH = STAGE;
    localparam int  HSH = hyp_shift(STAGE);
    localparam real SC  = 2.0 ** FZ;
    localparam real TC  = 2.0 ** (-CSH);
    localparam real TH  = 2.0 ** (-HSH);
    localparam logic signed [ZW-1:0] K_CIRC = ZW'($rtoi($atan(TC) * SC + 0.5));
    localparam logic signed [ZW-1:0] K_LIN  = ZW'($rtoi(TC * SC + 0.5));
    localparam logic signed [ZW-1:0] K_HYP  = ZW'($rtoi(0.5 * $ln((1.0 + TH) / (1.0 - TH)) * SC + 0.5));

    logic                 dpos;
    logic signed [IW-1:0] xs, ys, xn, yn;
    logic signed [ZW-1:0] ang, zn;

    // Direction: rotate steers z to zero, vector steers y to zero.
    assign dpos = (mode_i == MD_ROTATE) ? ~z_i[ZW-1] : y_i[IW-1];

    // Shifted cross terms, angle constant and next state per coordinate system.
    always_comb begin
        if (coord_i == CS_HYP) begin
            xs = x_i >>> HSH;
            ys = y_i >>> HSH;
        end else begin
            xs = x_i >>> CSH;
            ys = y_i >>> CSH;
        end
        case (coord_i)
            CS_CIRC: begin
                ang = K_CIRC;
                xn  = dpos ? (x_i - ys) : (x_i + ys);
            end
            CS_HYP: begin
                ang = K_HYP;
                xn  = dpos ? (x_i + ys) : (x_i - ys);
            end
            default: begin
                ang = K_LIN;
                xn  = x_i;
            end
        endcase
        yn = dpos ? (y_i + xs) : (y_i - xs);
        zn = dpos ? (z_i - ang) : (z_i + ang);
    end

    // Stage register: valid is reset, payload follows.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
        mode_o  <= mode_i;
        coord_o <= coord_i;
        x_o     <= xn;
        y_o     <= yn;
        z_o     <= zn;
    end

    AST_ROT_Z_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && mode_i == MD_ROTATE && z_i >= 0) |=> (z_o <= $past(z_i))); // R1

    AST_VEC_Y_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && mode_i == MD_VECTOR && y_i >= 0 && x_i > 0) |=> (y_o <= $past(y_i))); // R2

    AST_LIN_X_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && coord_i == CS_LIN) |=> (x_o == $past(x_i))); // R4

    AST_TAG_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (vld_o && mode_o == $past(mode_i) && coord_o == $past(coord_i))); // R8

endmodule

// File: rtl/cordic_pipe.sv
// Top of the unified CORDIC pipeline: an entry pre-rotation register
// followed by N plus hyperbolic-repeat micro-rotation stages. Accepts one
// operand per clock. Results keep the uncompensated gain.
// Assumes ZW >= 4 so that z holds +/-pi with ZW-3 fraction bits.
module cordic_pipe
    import cordic_pkg::*;
#(
    parameter int DW = 16,
    parameter int ZW = 18,
    parameter int N  = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_mode,
    input  logic [1:0]              in_coord,
    input  logic signed [DW-1:0]    in_x,
    input  logic signed [DW-1:0]    in_y,
    input  logic signed [ZW-1:0]    in_z,
    output logic                    out_valid,
    output logic                    out_mode,
    output logic [1:0]              out_coord,
    output logic signed [DW+1:0]    out_x,
    output logic signed [DW+1:0]    out_y,
    output logic signed [ZW-1:0]    out_z
);
    localparam int GUARD = 2;
    localparam int IW    = DW + GUARD;
    localparam int FZ    = ZW - 3;
    localparam int NST   = N + hyp_repeats(N);

    logic                 vld_p   [0:NST];
    cmode_e               mode_p  [0:NST];
    csys_e                coord_p [0:NST];
    logic signed [IW-1:0] x_p     [0:NST];
    logic signed [IW-1:0] y_p     [0:NST];
    logic signed [ZW-1:0] z_p     [0:NST];

    cordic_prerot #(.DW(DW), .IW(IW), .ZW(ZW), .FZ(FZ)) u_prerot (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (in_valid),
        .mode_i  (cmode_e'(in_mode)),
        .coord_i (csys_e'(in_coord)),
        .x_i     (in_x),
        .y_i     (in_y),
        .z_i     (in_z),
        .vld_o   (vld_p[0]),
        .mode_o  (mode_p[0]),
        .coord_o (coord_p[0]),
        .x_o     (x_p[0]),
        .y_o     (y_p[0]),
        .z_o     (z_p[0])
    );

    // One registered micro-rotation per pipeline step.
    for (genvar s = 0; s < NST; s++) begin : g_stage
        cordic_stage #(.IW(IW), .ZW(ZW), .FZ(FZ), .STAGE(s)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld_i   (vld_p[s]),
            .mode_i  (mode_p[s]),
            .coord_i (coord_p[s]),
            .x_i     (x_p[s]),
            .y_i     (y_p[s]),
            .z_i     (z_p[s]),
            .vld_o   (vld_p[s+1]),
            .mode_o  (mode_p[s+1]),
            .coord_o (coord_p[s+1]),
            .x_o     (x_p[s+1]),
            .y_o     (y_p[s+1]),
            .z_o     (z_p[s+1])
        );
    end

    assign out_valid = vld_p[NST];
    assign out_mode  = logic'(mode_p[NST]);
    assign out_coord = 2'(coord_p[NST]);
    assign out_x     = x_p[NST];
    assign out_y     = y_p[NST];
    assign out_z     = z_p[NST];

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R9

endmodule

// File: tb/tb_cordic_pipe.sv
// Directed bench for cordic_pipe with default parameters (DW=16, ZW=18, N=14).
module tb_cordic_pipe;
    localparam int  CLK_PERIOD = 10;
    localparam int  DW  = 16;
    localparam int  ZW  = 18;
    localparam int  LAT = 17;          // R8: 14 + 2 + 1
    localparam real ZS  = 32768.0;     // 2^(ZW-3)
    localparam real KC  = 1.6467605;
    localparam real KH  = 0.82816;
    localparam real TXY = 24.0;
    localparam real TZ  = 0.002;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_mode = 1'b0;
    logic [1:0]           in_coord = 2'd0;
    logic signed [DW-1:0] in_x = '0;
    logic signed [DW-1:0] in_y = '0;
    logic signed [ZW-1:0] in_z = '0;
    logic                 out_valid, out_mode;
    logic [1:0]           out_coord;
    logic signed [DW+1:0] out_x, out_y;
    logic signed [ZW-1:0] out_z;

    int checks = 0;
    int fails  = 0;

    cordic_pipe #(.DW(DW), .ZW(ZW), .N(14)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk_close(input string req, input string what, input real act, input real exp, input real tol);
        checks++;
        if ((act - exp > tol) || (exp - act > tol)) begin
            fails++;
            $display("FAIL %s %s: actual %f expected %f", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic md, input logic [1:0] cs, input int x, input int y, input real z);
        in_valid = 1'b1;
        in_mode  = md;
        in_coord = cs;
        in_x     = DW'(x);
        in_y     = DW'(y);
        in_z     = ZW'($rtoi(z * ZS + ((z >= 0.0) ? 0.5 : -0.5)));
    endtask

    // Single operand; returns results sampled exactly LAT edges later.
    task automatic run_op(input logic md, input logic [1:0] cs, input int x, input int y, input real z,
                          output real xo, output real yo, output real zo, output int vo);
        @(negedge clk);
        drive(md, cs, x, y, z);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        xo = real'(out_x);
        yo = real'(out_y);
        zo = real'(out_z) / ZS;
        vo = int'(out_valid);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R9", "valid in reset", int'(out_valid), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R9", "valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_circ_rot(input int x, input int y, input real z, input string req);
        real xo, yo, zo;
        int vo;
        run_op(1'b0, 2'd0, x, y, z, xo, yo, zo, vo);
        chk_eq(req, "valid", vo, 1);
        chk_close(req, "x", xo, KC * (x * $cos(z) - y * $sin(z)), TXY);
        chk_close(req, "y", yo, KC * (y * $cos(z) + x * $sin(z)), TXY);
    endtask

    task automatic t_circ_vec(input int x, input int y);
        real xo, yo, zo;
        int vo;
        run_op(1'b1, 2'd0, x, y, 0.0, xo, yo, zo, vo);
        chk_close("R2", "mag", xo, KC * $sqrt(real'(x) * x + real'(y) * y), TXY);
        chk_close("R2", "y zero", yo, 0.0, TXY);
        chk_close("R2", "angle", zo, $atan2(real'(y), real'(x)), TZ);
    endtask

    task automatic t_lin();
        real xo, yo, zo;
        int vo;
        run_op(1'b0, 2'd1, 3000, 100, 1.25, xo, yo, zo, vo);
        chk_close("R4", "x held", xo, 3000.0, 0.0);
        chk_close("R4", "y mac", yo, 3850.0, TXY);
        run_op(1'b1, 2'd1, 4000, 6000, 0.1, xo, yo, zo, vo);
        chk_close("R5", "z div", zo, 1.6, TZ);
    endtask

    task automatic t_hyp_rot(input int x, input int y, input real z);
        real xo, yo, zo;
        int vo;
        run_op(1'b0, 2'd2, x, y, z, xo, yo, zo, vo);
        chk_close("R6", "x", xo, KH * (x * $cosh(z) + y * $sinh(z)), TXY);
        chk_close("R6", "y", yo, KH * (y * $cosh(z) + x * $sinh(z)), TXY);
    endtask

    task automatic t_hyp_vec();
        real xo, yo, zo;
        int vo;
        run_op(1'b1, 2'd2, 8000, 4000, 0.0, xo, yo, zo, vo);
        chk_close("R7", "x", xo, KH * $sqrt(64.0e6 - 16.0e6), TXY);
        chk_close("R7", "z", zo, 0.5 * $ln(1.5 / 0.5), TZ);
    endtask

    // R8: valid appears at exactly LAT and lasts one cycle.
    task automatic t_latency();
        @(negedge clk);
        drive(1'b0, 2'd0, 5000, 0, 0.3);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 2) @(posedge clk);
        @(negedge clk);
        chk_eq("R8", "valid at LAT-1", int'(out_valid), 0);
        @(negedge clk);
        chk_eq("R8", "valid at LAT", int'(out_valid), 1);
        @(negedge clk);
        chk_eq("R8", "valid at LAT+1", int'(out_valid), 0);
    endtask

    // R8: three operands back to back, each with its own mode/coordinate.
    task automatic t_stream();
        @(negedge clk);
        drive(1'b0, 2'd0, 10000, 0, 0.5);
        @(negedge clk);
        drive(1'b0, 2'd1, 2000, 0, 0.5);
        @(negedge clk);
        drive(1'b1, 2'd2, 8000, 4000, 0.0);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 3) @(posedge clk);
        @(negedge clk);
        chk_eq("R8", "stream0 valid", int'(out_valid), 1);
        chk_eq("R8", "stream0 coord", int'(out_coord), 0);
        chk_close("R8", "stream0 y", real'(out_y), KC * 10000.0 * $sin(0.5), TXY);
        @(negedge clk);
        chk_eq("R8", "stream1 coord", int'(out_coord), 1);
        chk_close("R8", "stream1 y", real'(out_y), 1000.0, TXY);
        @(negedge clk);
        chk_eq("R8", "stream2 mode", int'(out_mode), 1);
        chk_eq("R8", "stream2 coord", int'(out_coord), 2);
        @(negedge clk);
        chk_eq("R8", "stream end", int'(out_valid), 0);
    endtask

    initial begin
        t_reset();
        t_circ_rot(10000, 0, 0.6, "R1");
        t_circ_rot(8000, 3000, -1.2, "R1");
        t_circ_rot(9000, 2000, 2.5, "R3");
        t_circ_rot(9000, 2000, -2.8, "R3");
        t_circ_vec(7000, 5000);
        t_circ_vec(-6000, 4000);
        t_circ_vec(-5000, -7000);
        t_lin();
        t_hyp_rot(6000, 0, 0.5);
        t_hyp_rot(5000, 1000, -0.7);
        t_hyp_vec();
        t_latency();
        t_stream();
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

endmodule